// File: doc/BRIEF.md
# AHB data-phase ready and response multiplexer

This block joins four AHB slaves to a single master-side port. It decodes the upper address bits of the current address phase into a one-hot slave select. It then records which slave owns the following data phase. That record moves on only at a clock edge where the global ready is high. The ready, response and read data of the owning slave are steered back to the master. The same ready drives every slave's ready input, so each slave can tell when its address phase has been taken.

Addresses whose region matches no mapped slave go to a built-in default slave. The default slave gives a zero-wait OKAY to IDLE and BUSY transfers. It answers NONSEQ and SEQ transfers with a two-cycle ERROR. Because the mux follows the data-phase owner and not the slave being addressed now, a wait state from a stalled slave stays visible to the master even while the address lines already name a different slave.

Top module: `ahb_resp_mux`

## Requirements
- R1: After a synchronous reset the default slave owns the data phase: hready is 1, hresp is 0 (OKAY) and hrdata is 0, whatever the slave inputs are.
- R2: hsel bit k is 1 exactly when haddr_top equals k, for k from 0 to 3. For any other haddr_top value hsel is all zero. hsel does not depend on htrans.
- R3: At a clock edge where hready is 1, the slave selected by the current address becomes the data-phase owner. A haddr_top of 4 or more selects the default slave. From that edge on, hready and hresp equal the owner's hreadyout and hresp, even when the address names a different slave.
- R4: At a clock edge where hready is 0, the data-phase owner does not change, even if haddr_top or htrans change.
- R5: An accepted NONSEQ (2'b10) or SEQ (2'b11) transfer to an unmapped region gets two data cycles from the default slave. The first has hready 0 and hresp 1 (ERROR). The second has hready 1 and hresp 1.
- R6: An accepted IDLE (2'b00) or BUSY (2'b01) transfer to an unmapped region gets one data cycle with hready 1 and hresp 0.
- R7: hrdata follows the same data-phase owner as hready. A mapped owner's slv_hrdata slice k (bits 32k+31 down to 32k) is passed through. The default slave drives 0.
- R8: Several active unmapped transfers in a row each get the full two-cycle ERROR. Each one is accepted in the second cycle of the ERROR before it.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Bus clock |
| rst_n | input | 1 | Synchronous active-low reset |
| haddr_top | input | 4 | Upper HADDR bits of the current address phase |
| htrans | input | 2 | Transfer type of the current address phase |
| hsel | output | 4 | One-hot address-phase select to the mapped slaves |
| slv_hreadyout | input | 4 | Ready output of each mapped slave |
| slv_hresp | input | 4 | Response of each mapped slave, 1 = ERROR |
| slv_hrdata | input | 128 | Read data of the mapped slaves, 32 bits each |
| hready | output | 1 | Global ready, to the master and to every slave |
| hresp | output | 1 | Response to the master |
| hrdata | output | 32 | Read data to the master |

## Verification
In a single cycle the decoder is already selecting the next slave while the mux is still reporting the previous owner's wait state. The bench provokes this by giving each slave its own ready and data values and moving the address to another region while the owner holds its ready low, once with a legal master and once with an address that changes during a stall. In each cycle the outputs are compared against a bench model that keeps its own owner and default-slave state. A mux that looked at the present address instead of the owner would therefore show the wrong slave's ready or data.

// File: rtl/ahb_mux_pkg.sv
// Shared codes and types for the AHB data-phase response multiplexer.
// Assumes the single-bit response encoding (0 OKAY, 1 ERROR).
package ahb_mux_pkg;
    localparam logic [1:0] TR_IDLE   = 2'b00;
    localparam logic [1:0] TR_BUSY   = 2'b01;
    localparam logic [1:0] TR_NONSEQ = 2'b10;
    localparam logic [1:0] TR_SEQ    = 2'b11;

    localparam logic RESP_OKAY  = 1'b0;
    localparam logic RESP_ERROR = 1'b1;

    // Default-slave response sequencing
    typedef enum logic [1:0] {
        DS_IDLE = 2'd0,
        DS_ERR1 = 2'd1,
        DS_ERR2 = 2'd2
    } dflt_state_t;
endpackage

// File: rtl/ahb_mux_decode.sv
// Address-phase decoder. Maps region k (k < SLV_N) of the upper address bits
// to one-hot select bit k and to owner index k. Unmapped regions give no
// select bit and owner index SLV_N (the default slave).
// Assumes SLV_N <= 2**RB.
module ahb_mux_decode #(
    parameter int SLV_N = 4,
    parameter int RB    = 4,
    parameter int OW    = 3
) (
    input  logic [RB-1:0]    region,
    output logic [SLV_N-1:0] sel_onehot,
    output logic [OW-1:0]    sel_idx
);
    genvar gk;
    generate
        for (gk = 0; gk < SLV_N; gk++) begin : g_sel
            // One select bit per mapped region
            assign sel_onehot[gk] = (region == RB'(gk));
        end
    endgenerate

    // Encode the region into an owner index, default slave when unmapped
    always_comb begin
        sel_idx = OW'(SLV_N);
        for (int k = 0; k < SLV_N; k++) begin
            if (region == RB'(k)) sel_idx = OW'(k);
        end
    end
endmodule

// File: rtl/ahb_mux_owner.sv
// Data-phase owner register. Loads the address-phase owner index at each
// edge where the global ready is high and holds it otherwise.
// Resets to the default slave index.
module ahb_mux_owner #(
    parameter int OW      = 3,
    parameter int DEF_IDX = 4
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          ready,
    input  logic [OW-1:0] next_idx,
    output logic [OW-1:0] owner
);
    // Advance ownership only when the address phase is accepted
    always_ff @(posedge clk) begin
        if (!rst_n)     owner <= OW'(DEF_IDX);
        else if (ready) owner <= next_idx;
    end
endmodule

// File: rtl/ahb_mux_dflt.sv
// Default slave for unmapped regions. An accepted NONSEQ or SEQ transfer
// gives a two-cycle ERROR. Anything else gives a zero-wait OKAY.
// Assumes the caller only asserts take_active for unmapped addresses.
module ahb_mux_dflt
    import ahb_mux_pkg::*;
(
    input  logic       clk,
    input  logic       rst_n,
    input  logic       ready,
    input  logic       unmapped,
    input  logic [1:0] trans,
    output logic       d_ready,
    output logic       d_resp
);
    dflt_state_t state;
    logic        take_active;

    // Active transfer to the default slave accepted this edge
    assign take_active = ready && unmapped &&
                         ((trans == TR_NONSEQ) || (trans == TR_SEQ));

    // Step through the two ERROR cycles, then accept the next transfer
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            state <= DS_IDLE;
        end else begin
            case (state)
                DS_ERR1: state <= DS_ERR2;
                default: state <= take_active ? DS_ERR1 : DS_IDLE;
            endcase
        end
    end

    // Response outputs decoded from the sequencing state
    always_comb begin
        d_ready = (state != DS_ERR1);
        d_resp  = (state == DS_IDLE) ? RESP_OKAY : RESP_ERROR;
    end
endmodule

// File: rtl/ahb_mux_route.sv
// Response router. Passes the owning slave's ready, response and read data
// to the master. Owner index SLV_N selects the default slave, which returns
// zero data.
module ahb_mux_route #(
    parameter int SLV_N = 4,
    parameter int DW    = 32,
    parameter int OW    = 3
) (
    input  logic [OW-1:0]       owner,
    input  logic [SLV_N-1:0]    s_ready,
    input  logic [SLV_N-1:0]    s_resp,
    input  logic [SLV_N*DW-1:0] s_rdata,
    input  logic                d_ready,
    input  logic                d_resp,
    output logic                m_ready,
    output logic                m_resp,
    output logic [DW-1:0]       m_rdata
);
    // Select one source for all three return signals
    always_comb begin
        m_ready = d_ready;
        m_resp  = d_resp;
        m_rdata = '0;
        for (int k = 0; k < SLV_N; k++) begin
            if (owner == OW'(k)) begin
                m_ready = s_ready[k];
                m_resp  = s_resp[k];
                m_rdata = s_rdata[k*DW +: DW];
            end
        end
    end
endmodule

// File: rtl/ahb_resp_mux.sv
// AHB data-phase ready and response multiplexer, top level.
// Decodes the address phase and registers the owner into the data phase
// when hready is high. Returns the owner's ready, response and data.
// Assumes single transfers, one master port and a fixed region map.
module ahb_resp_mux #(
    parameter int SLV_N = 4,
    parameter int DW    = 32,
    parameter int RB    = 4
) (
    input  logic                clk,
    input  logic                rst_n,
    input  logic [RB-1:0]       haddr_top,
    input  logic [1:0]          htrans,
    output logic [SLV_N-1:0]    hsel,
    input  logic [SLV_N-1:0]    slv_hreadyout,
    input  logic [SLV_N-1:0]    slv_hresp,
    input  logic [SLV_N*DW-1:0] slv_hrdata,
    output logic                hready,
    output logic                hresp,
    output logic [DW-1:0]       hrdata
);
    localparam int OW      = $clog2(SLV_N + 1);
    localparam int DEF_IDX = SLV_N;

    logic [OW-1:0] addr_idx;
    logic [OW-1:0] dp_owner;
    logic          dflt_ready;
    logic          dflt_resp;
    logic          unmapped;

    ahb_mux_decode #(.SLV_N(SLV_N), .RB(RB), .OW(OW)) u_decode (
        .region     (haddr_top),
        .sel_onehot (hsel),
        .sel_idx    (addr_idx)
    );

    ahb_mux_owner #(.OW(OW), .DEF_IDX(DEF_IDX)) u_owner (
        .clk      (clk),
        .rst_n    (rst_n),
        .ready    (hready),
        .next_idx (addr_idx),
        .owner    (dp_owner)
    );

    // Unmapped when no mapped select bit is raised
    assign unmapped = (hsel == '0);

    ahb_mux_dflt u_dflt (
        .clk      (clk),
        .rst_n    (rst_n),
        .ready    (hready),
        .unmapped (unmapped),
        .trans    (htrans),
        .d_ready  (dflt_ready),
        .d_resp   (dflt_resp)
    );

    ahb_mux_route #(.SLV_N(SLV_N), .DW(DW), .OW(OW)) u_route (
        .owner   (dp_owner),
        .s_ready (slv_hreadyout),
        .s_resp  (slv_hresp),
        .s_rdata (slv_hrdata),
        .d_ready (dflt_ready),
        .d_resp  (dflt_resp),
        .m_ready (hready),
        .m_resp  (hresp),
        .m_rdata (hrdata)
    );
endmodule

// File: rtl/ahb_resp_mux_chk.sv
// Protocol checker for ahb_resp_mux, attached by bind. Relates the decoder,
// owner register and default slave over time.
module ahb_resp_mux_chk #(
    parameter int SLV_N = 4,
    parameter int OW    = 3
) (
    input logic             clk,
    input logic             rst_n,
    input logic [SLV_N-1:0] hsel,
    input logic             hready,
    input logic             hresp,
    input logic [OW-1:0]    dp_owner
);
    localparam logic [OW-1:0] DEF = OW'(SLV_N);

    // R1: first cycle out of reset is a ready OKAY from the default slave
    a_r1_reset_ready: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(rst_n) |-> (hready && !hresp && dp_owner == DEF));

    // R2: at most one mapped slave selected
    a_r2_onehot_sel: assert property (@(posedge clk) disable iff (!rst_n)
        $onehot0(hsel));

    // R4: a stalled edge keeps the owner
    a_r4_owner_hold: assert property (@(posedge clk) disable iff (!rst_n)
        !hready |=> $stable(dp_owner));

    // R3: an accepted unmapped address hands the data phase to the default slave
    a_r3_take_default: assert property (@(posedge clk) disable iff (!rst_n)
        (hready && hsel == '0) |=> (dp_owner == DEF));

    genvar gk;
    generate
        for (gk = 0; gk < SLV_N; gk++) begin : g_take
            // R3: an accepted mapped address hands the data phase to that slave
            a_r3_take_slave: assert property (@(posedge clk) disable iff (!rst_n)
                (hready && hsel[gk]) |=> (dp_owner == OW'(gk)));
        end
    endgenerate

    // R5: a default-slave wait cycle carries ERROR and is followed by ready ERROR
    a_r5_error_pair: assert property (@(posedge clk) disable iff (!rst_n)
        (dp_owner == DEF && !hready) |-> hresp);
    a_r5_error_second: assert property (@(posedge clk) disable iff (!rst_n)
        (dp_owner == DEF && !hready) |=> (hready && hresp));

    // R6: an OKAY from the default slave never waits
    a_r6_okay_zero_wait: assert property (@(posedge clk) disable iff (!rst_n)
        (dp_owner == DEF && !hresp) |-> hready);
endmodule

bind ahb_resp_mux ahb_resp_mux_chk #(.SLV_N(SLV_N), .OW(OW)) u_chk (
    .clk      (clk),
    .rst_n    (rst_n),
    .hsel     (hsel),
    .hready   (hready),
    .hresp    (hresp),
    .dp_owner (dp_owner)
);

// File: tb/ahb_resp_mux_bench.sv
// Self-checking bench: a per-cycle model of owner and default slave,
// directed corner cases and a swept region/transfer-type space.
module ahb_resp_mux_bench;
    localparam int N  = 4;
    localparam int DW = 32;

    logic            clk = 1'b0;
    logic            rst_n = 1'b0;
    logic [3:0]      haddr_top = '0;
    logic [1:0]      htrans = 2'b00;
    logic [N-1:0]    hsel;
    logic [N-1:0]    s_rdy = '1;
    logic [N-1:0]    s_resp = '0;
    logic [N*DW-1:0] s_data = '0;
    logic            hready;
    logic            hresp;
    logic [DW-1:0]   hrdata;

    int vectors = 0;
    int errors = 0;
    int m_owner = 4;     // model owner, 4 = default slave
    int m_def = 0;       // 0 idle, 1 first ERROR cycle, 2 second ERROR cycle
    bit last_ready = 1'b1;
    bit prev_stall = 1'b0;

    ahb_resp_mux u_ahb_resp_mux (
        .clk(clk), .rst_n(rst_n), .haddr_top(haddr_top), .htrans(htrans),
        .hsel(hsel), .slv_hreadyout(s_rdy), .slv_hresp(s_resp),
        .slv_hrdata(s_data), .hready(hready), .hresp(hresp), .hrdata(hrdata)
    );

    always #5 clk = ~clk;

    task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
        vectors++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s actual=%h expected=%h at %0t", tag, act, exp, $time);
        end
    endtask

    // Give every slave distinct data for this cycle
    task automatic fill_data(input int seed);
        for (int k = 0; k < N; k++)
            s_data[k*DW +: DW] = 32'hA000_0000 | (k << 24) | (seed & 32'hFFFF);
    endtask

    // One cycle: compare at mid-cycle, then advance the model at the edge
    task automatic step(input string tag);
        logic       e_rdy, e_resp;
        logic [31:0] e_data;
        logic [3:0]  e_sel;
        string       t;
        #1;
        e_sel = (haddr_top < 4) ? (4'b1 << haddr_top) : 4'b0;
        if (m_owner == 4) begin
            e_rdy = (m_def != 1); e_resp = (m_def != 0); e_data = 0;
        end else begin
            e_rdy = s_rdy[m_owner]; e_resp = s_resp[m_owner];
            e_data = s_data[m_owner*DW +: DW];
        end
        chk("R2 hsel decode", {28'b0, hsel}, {28'b0, e_sel});
        if (tag != "") t = tag;
        else if (m_owner == 4) t = (m_def != 0) ? "R5" : "R6";
        else t = prev_stall ? "R4" : "R3";
        chk({t, " hready"}, {31'b0, hready}, {31'b0, e_rdy});
        chk({t, " hresp"}, {31'b0, hresp}, {31'b0, e_resp});
        chk("R7 hrdata", hrdata, e_data);
        @(posedge clk);
        if (m_def == 1) m_def = 2;
        else if (e_rdy) m_def = (haddr_top >= 4 && htrans[1]) ? 1 : 0;
        if (e_rdy) m_owner = (haddr_top < 4) ? int'(haddr_top) : 4;
        last_ready = e_rdy;
        prev_stall = !e_rdy;
        @(negedge clk);
    endtask

    // Present a transfer and hold it until accepted
    task automatic issue(input logic [3:0] reg_i, input logic [1:0] tr, input string tag);
        haddr_top = reg_i; htrans = tr;
        do step(tag); while (!last_ready);
    endtask

    initial begin
        #(10 * 200000);
        errors++;
        $display("FAIL watchdog expired");
        $display("== %0d vectors applied, %0d miscompares ==", vectors, errors);
        $finish;
    end

    initial begin
        // R1: reset state with hostile slave inputs
        s_rdy = 4'b0000; s_resp = 4'b1111; fill_data(1);
        haddr_top = 4'd2; htrans = 2'b10;
        repeat (3) @(posedge clk);
        @(negedge clk);
        chk("R1 hready", {31'b0, hready}, 32'd1);
        chk("R1 hresp", {31'b0, hresp}, 32'd0);
        chk("R1 hrdata", hrdata, 32'd0);
        rst_n = 1'b1;
        haddr_top = 4'd15; htrans = 2'b00;
        s_rdy = '1; s_resp = '0;
        step("R1");

        // R3/R4: owner slave 1 stalls while the address moves to slave 3
        issue(4'd1, 2'b10, "");
        s_rdy = 4'b1101; s_resp = 4'b0010; fill_data(7);
        haddr_top = 4'd3; htrans = 2'b10;
        repeat (3) step("R4");
        s_rdy = 4'b1111;
        step("R3");
        s_rdy = 4'b0111; s_resp = 4'b1000;
        step("R3");
        s_rdy = '1; s_resp = '0;
        step("R3");

        // R8: back-to-back active transfers to unmapped regions
        issue(4'd9, 2'b10, "R8");
        issue(4'd12, 2'b11, "R8");
        issue(4'd4, 2'b10, "R8");
        // R6: idle and busy to unmapped
        issue(4'd7, 2'b00, "R6");
        issue(4'd15, 2'b01, "R6");
        issue(4'd0, 2'b00, "R6");
        step("");

        // Sweep all regions and transfer types under random slave readiness
        for (int rep = 0; rep < 8; rep++) begin
            for (int r = 0; r < 16; r++) begin
                for (int tr = 0; tr < 4; tr++) begin
                    haddr_top = 4'(r); htrans = 2'(tr);
                    do begin
                        s_rdy = 4'($urandom) | 4'($urandom);
                        s_resp = 4'($urandom) & 4'($urandom);
                        fill_data(int'($urandom));
                        step("");
                    end while (!last_ready);
                end
            end
        end

        $display("== %0d vectors applied, %0d miscompares ==", vectors, errors);
        $finish;
    end
endmodule